// File: doc/BRIEF.md
# Bus-Master Channel Control Registers

This block holds the software-visible control state of one bus-master DMA channel: a command byte, a status byte and a 32-bit pointer to the descriptor table. Software reaches these through an eight-byte register window. An access is one, two or four bytes wide at any byte offset. The command byte sits at offset 0, the status byte at offset 2, and the table pointer fills offsets 4 to 7, least significant byte first.

The block does not move data. It tells a separate descriptor walker when to start and when to cancel, and in which direction to move data. It gives the walker the table base and a fetch pointer. That fetch pointer is reloaded from the base each time a transfer is started.

The block also watches the drive interrupt line. It records each rising edge in status and forwards the line's level unchanged. The walker reports back through a done pulse and an error pulse.

Top module: `bm_chan_regs`

## Requirements
- R1: A command write stores only bit 0 (start) and bit 3 (direction, 1 = toward memory); reading offset 0 returns the written byte ANDed with 0x09, and `xfer_to_mem` equals the stored bit 3.
- R2: A command write whose bit 0 equals the stored start bit produces no `xfer_start` or `xfer_cancel` pulse and leaves the fetch pointer and the active flag unchanged.
- R3: A command write that changes start from 0 to 1 reloads `fetch_ptr` from `tbl_base`, sets status bit 0 (active) and pulses `xfer_start` for one cycle; all of this is visible in the cycle after the write edge.
- R4: A command write that changes start from 1 to 0 pulses `xfer_cancel` for one cycle and clears status bit 0, visible in the cycle after the write edge.
- R5: A status write (offset 2) copies bits 5 and 6 from the written byte and leaves status bit 0 unchanged; status bits 3, 4 and 7 always read 0.
- R6: In a status write, a 1 in bit 1 (error) or bit 2 (interrupt) clears that bit, and a 0 keeps it.
- R7: `irq_out` follows `drv_irq` in the same cycle at both levels; a rising edge of `drv_irq` sets status bit 2 at the next edge, and a level held high does not set the bit again after software clears it.
- R8: Table-pointer writes change only the addressed byte lanes among offsets 4 to 7 (lanes past offset 7 are dropped), and pointer bits 1:0 always read 0.
- R9: A `walk_done` pulse clears status bit 0; a `walk_err` pulse sets status bit 1 and clears status bit 0.
- R10: Reset clears the command, status, table pointer, fetch pointer and both pulses.
- R11: A read returns window byte `addr+k` in result byte k for k below the access width (`reg_size` 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes); result bytes past the width or past offset 7 read 0, as do offsets 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register window |
| reg_addr | input | 3 | Byte offset of the access |
| reg_size | input | 2 | Access width code |
| reg_wdata | input | 32 | Write data, byte 0 goes to `reg_addr` |
| reg_rdata | output | 32 | Read data for `reg_addr`/`reg_size` |
| drv_irq | input | 1 | Drive interrupt level |
| walk_done | input | 1 | Walker finished the transfer |
| walk_err | input | 1 | Walker hit an error |
| xfer_start | output | 1 | One-cycle start request to the walker |
| xfer_cancel | output | 1 | One-cycle cancel request to the walker |
| xfer_to_mem | output | 1 | Transfer direction |
| tbl_base | output | 32 | Descriptor table base |
| fetch_ptr | output | 32 | Descriptor fetch pointer, reloaded on start |
| status_o | output | 8 | Status byte |
| irq_out | output | 1 | Forwarded drive interrupt |

## Verification
The hardest state to reach has the start bit still set while the active flag has dropped. This happens when the walker finishes without software stopping the channel. A repeated write of start = 1 must then stay silent, because the bit did not change.

The stimulus sets start, then pulses `walk_done`, then writes start = 1 again. It checks that no start pulse appears and that the active flag stays clear. It then clears start and sets it again to confirm that both edges still act.

The status sweep puts every written byte against a status that has error, interrupt and active all set. To get there, it chains an error pulse, an interrupt edge and a start edge before each write.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  localparam int unsigned WIN_BYTES = 8;
  localparam int unsigned LANE_CMD  = 0;
  localparam int unsigned LANE_STAT = 2;
  localparam int unsigned LANE_PTR0 = 4;
  localparam logic [7:0] CMD_KEEP   = 8'h09;
  localparam logic [7:0] STAT_COPY  = 8'h60;
  localparam logic [7:0] STAT_W1C   = 8'h06;
  localparam logic [7:0] STAT_ACT   = 8'h01;

  function automatic int unsigned size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic lane_hit(input logic [2:0] a, input logic [1:0] sz,
                                    input int unsigned lane);
    int unsigned lo;
    lo = int'(a);
    return (lane >= lo) && (lane < lo + size_bytes(sz));
  endfunction

  function automatic logic [7:0] status_merge(input logic [7:0] old_v,
                                              input logic [7:0] w);
    return (w & STAT_COPY) | (old_v & STAT_ACT) | (old_v & ~w & STAT_W1C);
  endfunction
endpackage

// File: rtl/bm_lane_decode.sv
module bm_lane_decode #(
  parameter int unsigned NLANES = 8,
  parameter int unsigned DW     = 32
) (
  input  logic                 wr,
  input  logic [2:0]           addr,
  input  logic [1:0]           sz,
  input  logic [DW-1:0]        wdata,
  output logic [NLANES-1:0]    lane_we,
  output logic [NLANES-1:0][7:0] lane_wd
);
  import bmr_pkg::*;
  genvar g;
  generate
    for (g = 0; g < NLANES; g++) begin : g_lane
      logic [2:0] off;
      assign off        = 3'(g) - addr;
      assign lane_we[g] = wr && lane_hit(addr, sz, g);
      assign lane_wd[g] = wdata[{off[1:0], 3'b000} +: 8];
    end
  endgenerate
endmodule

// File: rtl/bm_cmd_ctl.sv
module bm_cmd_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wd,
  input  logic       active,
  output logic [7:0] cmd_q,
  output logic       start_rise,
  output logic       start_fall,
  output logic       xfer_start,
  output logic       xfer_cancel
);
  import bmr_pkg::*;
  assign start_rise = we && wd[0] && !cmd_q[0];
  assign start_fall = we && !wd[0] && cmd_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      xfer_start  <= 1'b0;
      xfer_cancel <= 1'b0;
    end else begin
      if (we) cmd_q <= wd & CMD_KEEP;
      xfer_start  <= start_rise && !active;
      xfer_cancel <= start_fall;
    end
  end
endmodule

// File: rtl/bm_status.sv
module bm_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wd,
  input  logic       start_rise,
  input  logic       start_fall,
  input  logic       irq_rise,
  input  logic       walk_done,
  input  logic       walk_err,
  output logic [7:0] stat_q
);
  import bmr_pkg::*;
  logic [7:0] nxt;

  always_comb begin
    nxt = stat_q;
    if (we) nxt = status_merge(stat_q, wd);
    if (start_fall)                nxt[0] = 1'b0;
    else if (start_rise)           nxt[0] = 1'b1;
    else if (walk_done || walk_err) nxt[0] = 1'b0;
    if (walk_err) nxt[1] = 1'b1;
    if (irq_rise) nxt[2] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= nxt;
  end
endmodule

// File: rtl/bm_ptr.sv
module bm_ptr #(
  parameter int unsigned PTR_W = 32,
  localparam int unsigned PB   = PTR_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PB-1:0]      lane_we,
  input  logic [PB-1:0][7:0] lane_wd,
  input  logic               start_rise,
  output logic [PTR_W-1:0]   base_q,
  output logic [PTR_W-1:0]   fetch_q
);
  genvar g;
  generate
    for (g = 0; g < PB; g++) begin : g_byte
      logic [7:0] keep;
      assign keep = (g == 0) ? 8'hFC : 8'hFF;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          base_q[8*g +: 8] <= '0;
        else if (lane_we[g]) base_q[8*g +: 8] <= lane_wd[g] & keep;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fetch_q <= '0;
    else if (start_rise) fetch_q <= base_q;
  end
endmodule

// File: rtl/bm_chan_regs.sv
module bm_chan_regs #(
  parameter int unsigned PTR_W = 32,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [1:0]       reg_size,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             drv_irq,
  input  logic             walk_done,
  input  logic             walk_err,
  output logic             xfer_start,
  output logic             xfer_cancel,
  output logic             xfer_to_mem,
  output logic [PTR_W-1:0] tbl_base,
  output logic [PTR_W-1:0] fetch_ptr,
  output logic [7:0]       status_o,
  output logic             irq_out
);
  import bmr_pkg::*;
  localparam int unsigned PB = PTR_W / 8;
  localparam int unsigned RB = DW / 8;

  logic [WIN_BYTES-1:0]      lane_we;
  logic [WIN_BYTES-1:0][7:0] lane_wd;
  logic [7:0] cmd_q;
  logic       start_rise, start_fall, irq_rise, irq_q;
  logic [WIN_BYTES-1:0][7:0] win;

  bm_lane_decode #(.NLANES(WIN_BYTES), .DW(DW)) u_dec (
    .wr(reg_wr), .addr(reg_addr), .sz(reg_size), .wdata(reg_wdata),
    .lane_we(lane_we), .lane_wd(lane_wd)
  );

  bm_cmd_ctl u_cmd (
    .clk(clk), .rst_n(rst_n), .we(lane_we[LANE_CMD]), .wd(lane_wd[LANE_CMD]),
    .active(status_o[0]), .cmd_q(cmd_q), .start_rise(start_rise),
    .start_fall(start_fall), .xfer_start(xfer_start), .xfer_cancel(xfer_cancel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= drv_irq;
  end
  assign irq_rise = drv_irq && !irq_q;
  assign irq_out  = drv_irq;

  bm_status u_stat (
    .clk(clk), .rst_n(rst_n), .we(lane_we[LANE_STAT]), .wd(lane_wd[LANE_STAT]),
    .start_rise(start_rise), .start_fall(start_fall), .irq_rise(irq_rise),
    .walk_done(walk_done), .walk_err(walk_err), .stat_q(status_o)
  );

  bm_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .lane_we(lane_we[LANE_PTR0 +: PB]), .lane_wd(lane_wd[LANE_PTR0 +: PB]),
    .start_rise(start_rise), .base_q(tbl_base), .fetch_q(fetch_ptr)
  );

  assign xfer_to_mem = cmd_q[3];

  always_comb begin
    win = '0;
    win[LANE_CMD]  = cmd_q;
    win[LANE_STAT] = status_o;
    for (int i = 0; i < PB; i++) win[LANE_PTR0 + i] = tbl_base[8*i +: 8];
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < RB; k++) begin
      if (k < size_bytes(reg_size) && (int'(reg_addr) + k) < WIN_BYTES)
        reg_rdata[8*k +: 8] = win[int'(reg_addr) + k];
    end
  end
endmodule

// File: rtl/bm_chan_regs_chk.sv
module bm_chan_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        drv_irq,
  input logic        walk_done,
  input logic        walk_err,
  input logic        xfer_start,
  input logic        xfer_cancel,
  input logic [31:0] tbl_base,
  input logic [31:0] fetch_ptr,
  input logic [7:0]  status_o,
  input logic        irq_out,
  input logic        start_rise,
  input logic        start_fall,
  input logic        irq_rise,
  input logic        cmd_start
);
  assert_same_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && reg_wdata[0] == cmd_start) |=> (!xfer_start && !xfer_cancel));

  assert_start_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise |=> (fetch_ptr == $past(tbl_base) && status_o[0] && xfer_start));

  assert_stop_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_fall |=> (!status_o[0] && xfer_cancel));

  assert_stat_keep_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd2 && !walk_done && !walk_err) |=> (status_o[0] == $past(status_o[0])));

  assert_irq_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise |=> status_o[2]);

  assert_irq_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == drv_irq);

  assert_ptr_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_base[1:0] == 2'b00) && (fetch_ptr[1:0] == 2'b00));

  assert_walk_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((walk_done || walk_err) && !start_rise) |=> !status_o[0]);

  assert_pulse_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_start && xfer_cancel));
endmodule

bind bm_chan_regs bm_chan_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .drv_irq(drv_irq), .walk_done(walk_done),
  .walk_err(walk_err), .xfer_start(xfer_start), .xfer_cancel(xfer_cancel),
  .tbl_base(tbl_base), .fetch_ptr(fetch_ptr), .status_o(status_o),
  .irq_out(irq_out), .start_rise(start_rise), .start_fall(start_fall),
  .irq_rise(irq_rise), .cmd_start(cmd_q[0])
);

// File: tb/tb_bm_chan_regs.sv
`timescale 1ns/1ps
module tb_bm_chan_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [1:0] reg_size = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic drv_irq = 1'b0, walk_done = 1'b0, walk_err = 1'b0;
  logic xfer_start, xfer_cancel, xfer_to_mem, irq_out;
  logic [31:0] tbl_base, fetch_ptr;
  logic [7:0] status_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bm_chan_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .drv_irq(drv_irq), .walk_done(walk_done), .walk_err(walk_err),
    .xfer_start(xfer_start), .xfer_cancel(xfer_cancel), .xfer_to_mem(xfer_to_mem),
    .tbl_base(tbl_base), .fetch_ptr(fetch_ptr), .status_o(status_o), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_size = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] s, output logic [31:0] d);
    reg_addr = a; reg_size = s;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) walk_done = 1'b1; else walk_err = 1'b1;
    @(negedge clk);
    walk_done = 1'b0; walk_err = 1'b0;
  endtask

  logic [7:0] mb [4];
  logic [31:0] r, base_m, fetch_m;
  logic start_m, act_m;

  function automatic logic [31:0] model_ptr();
    return {mb[3], mb[2], mb[1], mb[0]};
  endfunction

  initial begin
    #(8 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=done", n_chk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 status", {24'h0, status_o}, 32'h0);
    chk("R10 base", tbl_base, 32'h0);
    chk("R10 fetch", fetch_ptr, 32'h0);
    chk("R10 pulses", {30'h0, xfer_start, xfer_cancel}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, 2'd2, r);
    chk("R10 window", r, 32'h0);

    // R8: pointer lane sweep
    for (int i = 0; i < 4; i++) mb[i] = 8'h00;
    for (int off = 4; off < 8; off++) begin
      for (int s = 0; s < 3; s++) begin
        logic [31:0] d;
        int n;
        d = 32'h1357_9BDF + 32'(off * 32'h0101_0101) * 32'(s + 3);
        n = (s == 0) ? 1 : (s == 1) ? 2 : 4;
        for (int i = 0; i < 4; i++)
          if (i >= off - 4 && i < off - 4 + n) mb[i] = d[8*(i-(off-4)) +: 8];
        mb[0] = mb[0] & 8'hFC;
        wr(3'(off), 2'(s), d);
        chk("R8 base", tbl_base, model_ptr());
        rd(3'd4, 2'd2, r);
        chk("R8 readback", r, model_ptr());
      end
    end
    base_m = model_ptr();

    // R11: read width and window edges
    rd(3'd6, 2'd2, r);
    chk("R11 tail", r, {16'h0, mb[3], mb[2]});
    rd(3'd5, 2'd1, r);
    chk("R11 half", r, {16'h0, mb[2], mb[1]});
    rd(3'd4, 2'd3, r);
    chk("R11 size3", r, model_ptr());
    rd(3'd7, 2'd0, r);
    chk("R11 byte", r, {24'h0, mb[3]});

    // R1/R2/R3/R4: command sweep, each value written twice
    start_m = 1'b0; act_m = 1'b0; fetch_m = 32'h0;
    for (int v = 0; v < 256; v++) begin
      for (int rep = 0; rep < 2; rep++) begin
        logic rise, fall;
        rise = v[0] && !start_m;
        fall = !v[0] && start_m;
        if (rise) begin act_m = 1'b1; fetch_m = base_m; end
        if (fall) act_m = 1'b0;
        start_m = v[0];
        wr(3'd0, 2'd0, 32'(v));
        chk("R3 start pulse", {31'h0, xfer_start}, {31'h0, rise});
        chk("R4 cancel pulse", {31'h0, xfer_cancel}, {31'h0, fall});
        chk("R2 active", {31'h0, status_o[0]}, {31'h0, act_m});
        chk("R3 fetch", fetch_ptr, fetch_m);
        chk("R1 dir", {31'h0, xfer_to_mem}, {31'h0, v[3]});
        rd(3'd0, 2'd0, r);
        chk("R1 cmd read", r, 32'(v & 8'h09));
      end
    end

    // R2: walker finished while start still set; rewriting start is silent
    wr(3'd0, 2'd0, 32'h01);
    @(negedge clk);
    chk("R9 pre active", {31'h0, status_o[0]}, 32'h1);
    pulse(0);
    chk("R9 done clears", {31'h0, status_o[0]}, 32'h0);
    wr(3'd0, 2'd0, 32'h01);
    chk("R2 no restart", {31'h0, xfer_start}, 32'h0);
    chk("R2 stays idle", {31'h0, status_o[0]}, 32'h0);
    wr(3'd0, 2'd0, 32'h00);
    chk("R4 cancel after done", {31'h0, xfer_cancel}, 32'h1);
    wr(3'd0, 2'd0, 32'h01);
    chk("R3 restart", {31'h0, xfer_start}, 32'h1);
    chk("R3 restart active", {31'h0, status_o[0]}, 32'h1);

    // R9: walker error
    pulse(1);
    chk("R9 err sets", {30'h0, status_o[1:0]}, 32'h2);

    // R5/R6: status sweep against error, interrupt and active all set
    for (int w = 0; w < 256; w++) begin
      pulse(1);
      @(negedge clk); drv_irq = 1'b1;
      @(negedge clk); drv_irq = 1'b0;
      wr(3'd0, 2'd0, 32'h00);
      wr(3'd0, 2'd0, 32'h01);
      chk("R6 preset", {24'h0, status_o}, {24'h0, (status_o & 8'h60) | 8'h07});
      begin
        logic [7:0] wb, exp_s;
        wb = 8'(w);
        exp_s = (wb & 8'h60) | 8'h01 | (~wb & 8'h06);
        wr(3'd2, 2'd0, 32'(w));
        rd(3'd2, 2'd0, r);
        chk("R5 R6 status", r, {24'h0, exp_s});
      end
    end

    // R7: interrupt edge and pass-through
    wr(3'd2, 2'd0, 32'h06);
    @(negedge clk); drv_irq = 1'b1;
    #1 chk("R7 pass high", {31'h0, irq_out}, 32'h1);
    @(negedge clk);
    chk("R7 latch", {31'h0, status_o[2]}, 32'h1);
    wr(3'd2, 2'd0, 32'h04);
    @(negedge clk);
    chk("R7 held no reset", {31'h0, status_o[2]}, 32'h0);
    drv_irq = 1'b0;
    #1 chk("R7 pass low", {31'h0, irq_out}, 32'h0);
    @(negedge clk); drv_irq = 1'b1;
    @(negedge clk); drv_irq = 1'b0;
    chk("R7 relatch", {31'h0, status_o[2]}, 32'h1);

    // R10: reset in the middle of activity
    wr(3'd0, 2'd0, 32'h09);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R10 mid status", {24'h0, status_o}, 32'h0);
    chk("R10 mid base", tbl_base, 32'h0);
    chk("R10 mid fetch", fetch_ptr, 32'h0);
    chk("R10 mid dir", {31'h0, xfer_to_mem}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule